// File: doc/BRIEF.md
# Scatter-Gather Segment Splitter

This block turns a list of memory segments, each an address and a byte length, into the 128-bit descriptors that a DMA engine walks. A segment that would run across a 64 KiB address boundary is cut into several entries, so every entry stays inside one 64 KiB window. The source offers segments on a valid/ready port and flags the last segment of each list. Descriptors leave on a second valid/ready port, one per cycle when the consumer is ready.

The block keeps the most recent entry in a one-deep holding register. It sends an entry out only once it knows whether another entry follows. When the list ends, the held entry goes out with its end-of-list bit set. Entries are counted against a table capacity derived from a page size. When the list completes, the block pulses `done` with the entry count. If the list needs more entries than the table holds, it pulses `done` with `overflow` and a count of zero instead, after it has drained the rest of the list.

Top module: `sgs_splitter`

## Requirements
- R1: Each entry's length equals 0x10000 minus the low 16 bits of the current address, capped at the bytes left in the segment. The next entry of the same segment starts at the previous address plus that length.
- R2: No emitted entry crosses a 64 KiB boundary: low 16 address bits plus length never exceed 0x10000, and no entry has length zero.
- R3: Entry layout: `desc_data[127:96]` and `desc_data[63:32]` are zero. `desc_data[95:64]` is the 32-bit address with its four bytes reversed. `desc_data[31:0]` is the length word with its four bytes reversed. The length word carries the length in bits 16:0, zeros in bits 30:17 and the end-of-list flag in bit 31, so the flag appears at `desc_data[7]`.
- R4: The end-of-list flag is set on the final entry of a list and on no other entry. `done` follows in the cycle after that entry is accepted.
- R5: A zero-length segment adds no entries. A list ends with the segment that has `seg_last` set, even if its length is zero. A list with no data produces no entries and a `done` with count 0 and `overflow` low.
- R6: `done` is a one-cycle pulse. When `overflow` is low, `done_count` equals the number of entries emitted for that list.
- R7: If a list needs more than CAP entries, the block emits at most CAP-1 entries with no end-of-list flag. It accepts and drops the remaining segments up to and including the one with `seg_last`, then pulses `done` with `overflow` high and `done_count` zero.
- R8: Out of reset, `seg_ready` is high and `desc_valid` and `done` are low. While `desc_valid` is high and `desc_ready` low, `desc_data` holds its value. `seg_ready` is low whenever `desc_valid` is high.
- R9: CAP equals PAGE_BYTES/64, which is 64 for the default 4096-byte page. A list of exactly CAP entries completes without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when both high |
| seg_addr | input | 32 | Segment start address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Segment is the last of its list |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Consumer takes descriptor |
| desc_data | output | 128 | Descriptor in the R3 layout |
| done | output | 1 | One-cycle list completion pulse |
| done_count | output | $clog2(CAP+1) | Entries emitted (zero on overflow) |
| overflow | output | 1 | List exceeded table capacity (with done) |

## Verification
On every cycle the assertions check each entry offered on the output port. They confirm that it stays within one 64 KiB window, has a nonzero length, and keeps the fixed zero words and reserved bits. They also check that a stalled entry stays stable, that `done` lasts one cycle, that an overflow reports a zero count, and that an end-of-list entry is followed by `done`. The split lengths, the address chaining across entries, and where the end-of-list flag lands need the bench's reference model. The same holds for dropped zero-length segments, the exact capacity limit and the discard after overflow, which show only in the bench's scenarios.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

    localparam int CHUNK_W  = 17;
    localparam int DESC_W   = 128;

    typedef enum logic [2:0] {
        ST_ACCEPT  = 3'd0,
        ST_SPLIT   = 3'd1,
        ST_FLUSH   = 3'd2,
        ST_DISCARD = 3'd3,
        ST_DONE    = 3'd4
    } sgs_state_e;

    function automatic logic [31:0] bswap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/sgs_chunk_calc.sv
module sgs_chunk_calc #(
    parameter int LEN_W = 24
) (
    input  logic [15:0]                 addr_lo,
    input  logic [LEN_W-1:0]            rem,
    output logic [sgs_pkg::CHUNK_W-1:0] chunk,
    output logic                        seg_end
);
    localparam int CW = sgs_pkg::CHUNK_W;
    localparam int MW = (LEN_W > CW) ? LEN_W : CW;

    logic [CW-1:0] room;
    logic [MW-1:0] room_w;
    logic [MW-1:0] rem_w;

    always_comb begin
        room    = 17'h10000 - {1'b0, addr_lo};
        room_w  = MW'(room);
        rem_w   = MW'(rem);
        seg_end = (rem_w <= room_w);
        chunk   = seg_end ? CW'(rem_w) : room;
    end
endmodule

// File: rtl/sgs_desc_pack.sv
module sgs_desc_pack (
    input  logic [31:0]                 addr,
    input  logic [sgs_pkg::CHUNK_W-1:0] len,
    input  logic                        eol,
    output logic [sgs_pkg::DESC_W-1:0]  desc
);
    logic [31:0] len_word;

    always_comb begin
        len_word = {eol, 14'd0, len};
        desc     = {32'd0, sgs_pkg::bswap32(addr), 32'd0, sgs_pkg::bswap32(len_word)};
    end
endmodule

// File: rtl/sgs_splitter.sv
module sgs_splitter #(
    parameter int PAGE_BYTES = 4096,
    parameter int LEN_W      = 24,
    localparam int CAP       = PAGE_BYTES / 64,
    localparam int CNT_W     = $clog2(CAP + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       seg_valid,
    output logic                       seg_ready,
    input  logic [31:0]                seg_addr,
    input  logic [LEN_W-1:0]           seg_len,
    input  logic                       seg_last,
    output logic                       desc_valid,
    input  logic                       desc_ready,
    output logic [sgs_pkg::DESC_W-1:0] desc_data,
    output logic                       done,
    output logic [CNT_W-1:0]           done_count,
    output logic                       overflow
);
    import sgs_pkg::*;

    typedef struct packed {
        sgs_state_e          state;
        logic [31:0]         addr;
        logic [LEN_W-1:0]    rem;
        logic                last;
        logic                hold_vld;
        logic [31:0]         hold_addr;
        logic [CHUNK_W-1:0]  hold_len;
        logic [CNT_W-1:0]    cnt;
        logic                ovf;
    } regs_t;

    regs_t r_q, r_d;

    logic [CHUNK_W-1:0] chunk;
    logic               seg_end;
    logic               eol_flag;

    sgs_chunk_calc #(.LEN_W(LEN_W)) u_calc (
        .addr_lo (r_q.addr[15:0]),
        .rem     (r_q.rem),
        .chunk   (chunk),
        .seg_end (seg_end)
    );

    sgs_desc_pack u_pack (
        .addr (r_q.hold_addr),
        .len  (r_q.hold_len),
        .eol  (eol_flag),
        .desc (desc_data)
    );

    always_comb begin
        r_d        = r_q;
        seg_ready  = 1'b0;
        desc_valid = 1'b0;
        eol_flag   = 1'b0;
        done       = 1'b0;
        unique case (r_q.state)
            ST_ACCEPT: begin
                seg_ready = 1'b1;
                if (seg_valid) begin
                    r_d.addr = seg_addr;
                    r_d.rem  = seg_len;
                    r_d.last = seg_last;
                    if (seg_len != '0) begin
                        r_d.state = ST_SPLIT;
                    end else if (seg_last) begin
                        r_d.state = ST_FLUSH;
                    end
                end
            end
            ST_SPLIT: begin
                if (r_q.cnt == CNT_W'(CAP)) begin
                    r_d.ovf      = 1'b1;
                    r_d.hold_vld = 1'b0;
                    r_d.state    = r_q.last ? ST_DONE : ST_DISCARD;
                end else begin
                    desc_valid = r_q.hold_vld;
                    if (!r_q.hold_vld || desc_ready) begin
                        r_d.hold_vld  = 1'b1;
                        r_d.hold_addr = r_q.addr;
                        r_d.hold_len  = chunk;
                        r_d.cnt       = r_q.cnt + CNT_W'(1);
                        r_d.addr      = r_q.addr + 32'(chunk);
                        r_d.rem       = r_q.rem - LEN_W'(chunk);
                        if (seg_end) begin
                            r_d.state = r_q.last ? ST_FLUSH : ST_ACCEPT;
                        end
                    end
                end
            end
            ST_FLUSH: begin
                if (r_q.hold_vld) begin
                    desc_valid = 1'b1;
                    eol_flag   = 1'b1;
                    if (desc_ready) begin
                        r_d.hold_vld = 1'b0;
                        r_d.state    = ST_DONE;
                    end
                end else begin
                    r_d.state = ST_DONE;
                end
            end
            ST_DISCARD: begin
                seg_ready = 1'b1;
                if (seg_valid && seg_last) begin
                    r_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                done         = 1'b1;
                r_d.state    = ST_ACCEPT;
                r_d.cnt      = '0;
                r_d.ovf      = 1'b0;
                r_d.hold_vld = 1'b0;
            end
            default: r_d.state = ST_ACCEPT;
        endcase
    end

    assign done_count = (done && !r_q.ovf) ? r_q.cnt : '0;
    assign overflow   = done && r_q.ovf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/sgs_splitter_chk.sv
module sgs_splitter_chk #(
    parameter int PAGE_BYTES = 4096,
    localparam int CAP       = PAGE_BYTES / 64,
    localparam int CNT_W     = $clog2(CAP + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               seg_ready,
    input logic               desc_valid,
    input logic               desc_ready,
    input logic [127:0]       desc_data,
    input logic               done,
    input logic [CNT_W-1:0]   done_count,
    input logic               overflow
);
    logic [15:0] a_lo;
    logic [31:0] lw;

    always_comb begin
        a_lo = {desc_data[87:80], desc_data[95:88]};
        lw   = sgs_pkg::bswap32(desc_data[31:0]);
    end

    AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (({1'b0, a_lo} + lw[16:0]) <= 17'h10000) && (lw[16:0] != '0)); // R2

    AST_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (desc_data[127:96] == '0) && (desc_data[63:32] == '0) && (lw[30:17] == '0)); // R3

    AST_EOL_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_ready && lw[31]) |=> done); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_OVF_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> done && (done_count == '0)); // R7

    AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_ready) |=> desc_valid && $stable(desc_data)); // R8

    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> !seg_ready); // R8

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_count <= CNT_W'(CAP))); // R9
endmodule

bind sgs_splitter sgs_splitter_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .seg_ready  (seg_ready),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .desc_data  (desc_data),
    .done       (done),
    .done_count (done_count),
    .overflow   (overflow)
);

// File: tb/sgs_splitter_test.sv
module sgs_splitter_test;
    localparam int PAGE_BYTES = 4096;
    localparam int LEN_W      = 24;
    localparam int CAP        = PAGE_BYTES / 64;
    localparam int CNT_W      = $clog2(CAP + 1);
    localparam int WD_CYCLES  = 150000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               seg_valid = 1'b0;
    logic               seg_ready;
    logic [31:0]        seg_addr = '0;
    logic [LEN_W-1:0]   seg_len = '0;
    logic               seg_last = 1'b0;
    logic               desc_valid;
    logic               desc_ready = 1'b0;
    logic [127:0]       desc_data;
    logic               done;
    logic [CNT_W-1:0]   done_count;
    logic               overflow;

    always #10 clk = ~clk;

    sgs_splitter #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
        .done(done), .done_count(done_count), .overflow(overflow)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int dones_seen = 0;
    int last_count = -1;
    int ready_mode = 0;
    logic [15:0]  lfsr = 16'hACE1;
    logic [127:0] exp_desc[$];
    int           exp_cnt[$];
    bit           exp_ovf[$];
    int unsigned  q_addr[$];
    int unsigned  q_len[$];
    bit           q_last[$];
    bit           prev_stall = 1'b0;
    logic [127:0] prev_data = '0;
    logic [127:0] e_item;

    function automatic logic [31:0] sw(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [127:0] mk(input int unsigned a, input int unsigned l);
        logic [31:0] lw;
        lw = {15'd0, l[16:0]};
        return {32'd0, sw(a), 32'd0, sw(lw)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_test();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (ready_mode == 2)      desc_ready <= 1'b0;
        else if (ready_mode == 1) desc_ready <= 1'b1;
        else                      desc_ready <= lfsr[0] | lfsr[2];
    end

    // Per-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (prev_stall)
                chk(desc_valid && (desc_data == prev_data), "R8 stalled entry held", desc_data, prev_data);
            prev_stall = desc_valid && !desc_ready;
            prev_data  = desc_data;
            if (desc_valid && desc_ready) begin
                if (exp_desc.size() == 0) begin
                    chk(1'b0, "R5 R7 unexpected entry", desc_data, '0);
                end else begin
                    e_item = exp_desc.pop_front();
                    chk(desc_data == e_item, "R1 R2 R3 R4 entry", desc_data, e_item);
                end
            end
            if (done) begin
                if (exp_cnt.size() == 0) begin
                    chk(1'b0, "R6 unexpected done", 128'(done_count), '0);
                end else begin
                    int  ec;
                    bit  eo;
                    ec = exp_cnt.pop_front();
                    eo = exp_ovf.pop_front();
                    chk((done_count == CNT_W'(ec)) && (overflow == eo), "R5 R6 R7 result",
                        {overflow, 120'd0, done_count}, {eo, 120'd0, CNT_W'(ec)});
                end
                last_count = int'(done_count);
                dones_seen++;
            end else begin
                chk(!overflow, "R7 overflow without done", 128'(overflow), '0);
            end
            if (cyc > WD_CYCLES) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD_CYCLES);
                finish_test();
            end
        end
    end

    task automatic add_seg(input int unsigned a, input int unsigned l, input bit t);
        q_addr.push_back(a);
        q_len.push_back(l);
        q_last.push_back(t);
    endtask

    task automatic build_expect();
        logic [127:0] tmp[$];
        logic [127:0] t;
        int cnt = 0;
        bit ovf = 0;
        for (int i = 0; i < q_addr.size(); i++) begin
            int unsigned a = q_addr[i];
            int unsigned r = q_len[i];
            while (r > 0 && !ovf) begin
                if (cnt == CAP) begin
                    ovf = 1;
                end else begin
                    int unsigned c = 32'h10000 - (a & 32'hFFFF);
                    if (c > r) c = r;
                    tmp.push_back(mk(a, c));
                    cnt++;
                    a += c;
                    r -= c;
                end
            end
        end
        if (ovf) begin
            for (int i = 0; i < CAP - 1; i++) exp_desc.push_back(tmp[i]);
            exp_cnt.push_back(0);
            exp_ovf.push_back(1'b1);
        end else begin
            if (tmp.size() > 0) begin
                t = tmp.pop_back();
                t[7] = 1'b1;
                tmp.push_back(t);
            end
            foreach (tmp[i]) exp_desc.push_back(tmp[i]);
            exp_cnt.push_back(cnt);
            exp_ovf.push_back(1'b0);
        end
    endtask

    task automatic run_list();
        int target;
        build_expect();
        target = dones_seen + 1;
        while (q_addr.size() > 0) begin
            @(negedge clk);
            seg_valid = 1'b1;
            seg_addr  = q_addr.pop_front();
            seg_len   = LEN_W'(q_len.pop_front());
            seg_last  = q_last.pop_front();
            while (!seg_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        seg_valid = 1'b0;
        seg_last  = 1'b0;
        while (dones_seen < target) @(negedge clk);
        chk(exp_desc.size() == 0, "R4 R7 all entries seen", 128'(exp_desc.size()), '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(seg_ready && !desc_valid && !done, "R8 reset state",
            {125'd0, seg_ready, desc_valid, done}, {125'd0, 3'b100});

        // R1: single aligned segment
        add_seg(32'h1000_0000, 32'h200, 1'b1);
        run_list();
        // R1 R2: crossing a boundary
        add_seg(32'h0001_FF00, 32'h300, 1'b1);
        run_list();
        // R1: multi-window segment then full-window segment
        add_seg(32'h0003_8000, 32'h20000, 1'b0);
        add_seg(32'h0005_0000, 32'h10000, 1'b1);
        run_list();
        // R5: zero-length segment in the middle, one-byte splits
        add_seg(32'h0000_0100, 32'h40, 1'b0);
        add_seg(32'h0000_0000, 32'h0, 1'b0);
        add_seg(32'h0000_FFFF, 32'h2, 1'b1);
        run_list();
        // R4 R5: list closed by a zero-length last segment
        add_seg(32'h0000_2000, 32'h100, 1'b0);
        add_seg(32'h0000_0000, 32'h0, 1'b1);
        run_list();
        // R5: empty list
        add_seg(32'h0, 32'h0, 1'b1);
        run_list();
        chk(last_count == 0, "R5 empty count", 128'(last_count), '0);
        // R9: exactly CAP entries
        ready_mode = 1;
        add_seg(32'h0, CAP * 32'h10000, 1'b1);
        run_list();
        chk(last_count == CAP, "R9 full table count", 128'(last_count), 128'(CAP));
        ready_mode = 0;
        // R7: overflow inside the last segment
        add_seg(32'h0, (CAP - 1) * 32'h10000, 1'b0);
        add_seg(32'h1000_0000, 32'h20000, 1'b1);
        run_list();
        // R7: overflow early, remaining segments dropped
        add_seg(32'h0, (CAP + 1) * 32'h10000, 1'b0);
        add_seg(32'h50, 32'h10, 1'b0);
        add_seg(32'h60, 32'h10, 1'b1);
        run_list();
        // R8: consumer stalled for a while, then a normal list after overflow
        ready_mode = 2;
        add_seg(32'h0002_FFF0, 32'h40, 1'b0);
        add_seg(32'h0007_0000, 32'h18000, 1'b1);
        fork
            run_list();
            begin
                repeat (8) @(negedge clk);
                ready_mode = 0;
            end
        join
        chk(last_count == 4, "R1 R6 count after stall", 128'(last_count), 128'd4);

        repeat (4) @(negedge clk);
        finish_test();
    end
endmodule